// File: doc/BRIEF.md
# Shared-Term Constant Multiplier Bank

This block multiplies one unsigned operand by a fixed set of constants at the same time and uses no multiplier: only wiring shifts and two-input adders. Four of the products (9, 13, 18 and 21 times the operand) come from one graph. That graph first forms five times the operand and then reuses it. Nine, thirteen and twenty-one times the operand are each five times the operand plus one shifted copy of the operand. Eighteen times the operand is nine times the operand moved up one place, so it needs no adder. The whole graph uses four adders. Building the same four constants independently would take six.

A separate single-constant path gives 45 times the operand by factoring 45 as 5 times 9. It forms five times the operand and then adds that value to itself shifted up three places, which uses two adders. The block is purely combinational. Each output is just wide enough to hold the largest product the operand width allows, so no output can overflow. A surrounding datapath drives the operand and takes whichever scaled copies it needs in the same cycle.

Top module: `const_mult_bank`

## Requirements
- R1: `prod9` equals 9 × `xIn` for every value of `xIn`.
- R2: `prod13` equals 13 × `xIn` for every value of `xIn`.
- R3: `prod21` equals 21 × `xIn` for every value of `xIn`.
- R4: `prod18` equals 18 × `xIn` for every value of `xIn`. It is always twice `prod9`, so its bit 0 is always 0.
- R5: `prod45` equals 45 × `xIn` for every value of `xIn`.
- R6: Output widths are IN_W+4 for `prod9` and `prod13`, IN_W+5 for `prod18` and `prod21`, and IN_W+6 for `prod45`. At the largest operand (all ones), every output still equals the exact product.
- R7: When `xIn` is 0, every output is 0.
- R8: The outputs depend only on the present value of `xIn`. A change on `xIn` shows on every output without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| xIn | input | IN_W | Unsigned operand |
| prod9 | output | IN_W+4 | 9 × operand |
| prod13 | output | IN_W+4 | 13 × operand |
| prod18 | output | IN_W+5 | 18 × operand |
| prod21 | output | IN_W+5 | 21 × operand |
| prod45 | output | IN_W+6 | 45 × operand |

## Verification
The bench builds the block with the default IN_W of 8. At that width every one of the 256 operand values can be applied, so each product is compared against the true multiplication over the full input range. The sweep includes the all-ones operand, where each output uses its top bit, and the zero operand. A separate step changes the operand between clock edges to show that the outputs follow with no register in the path.

// File: rtl/mcm_pkg.sv
package mcm_pkg;
  // Extra bits each product needs above the operand width (ceil(log2(C))).
  localparam int unsigned EXT_5  = 3;
  localparam int unsigned EXT_9  = 4;
  localparam int unsigned EXT_13 = 4;
  localparam int unsigned EXT_18 = 5;
  localparam int unsigned EXT_21 = 5;
  localparam int unsigned EXT_45 = 6;
endpackage

// File: rtl/mcm_add.sv
// Unsigned two-input adder; operands are zero-extended to the sum width.
module mcm_add #(
  parameter int unsigned AW = 8,
  parameter int unsigned BW = 8,
  parameter int unsigned SW = 9
) (
  input  logic [AW-1:0] opA,
  input  logic [BW-1:0] opB,
  output logic [SW-1:0] sum
);
  assign sum = SW'(opA) + SW'(opB);
endmodule

// File: rtl/mcm_shared_core.sv
// Shared graph: one 5X term feeds three adders; 18X is a wire shift of 9X.
module mcm_shared_core
  import mcm_pkg::*;
#(
  parameter int unsigned IN_W = 8
) (
  input  logic [IN_W-1:0]        xIn,
  output logic [IN_W+EXT_9-1:0]  prod9,
  output logic [IN_W+EXT_13-1:0] prod13,
  output logic [IN_W+EXT_18-1:0] prod18,
  output logic [IN_W+EXT_21-1:0] prod21
);
  localparam int unsigned FIVE_W = IN_W + EXT_5;

  logic [FIVE_W-1:0] fiveX;

  // adder 1: 4X + X
  mcm_add #(.AW(IN_W+2), .BW(IN_W), .SW(FIVE_W)) u_add5 (
    .opA({xIn, 2'b00}), .opB(xIn), .sum(fiveX));

  // adder 2: 5X + 4X
  mcm_add #(.AW(FIVE_W), .BW(IN_W+2), .SW(IN_W+EXT_9)) u_add9 (
    .opA(fiveX), .opB({xIn, 2'b00}), .sum(prod9));

  // adder 3: 5X + 8X
  mcm_add #(.AW(FIVE_W), .BW(IN_W+3), .SW(IN_W+EXT_13)) u_add13 (
    .opA(fiveX), .opB({xIn, 3'b000}), .sum(prod13));

  // adder 4: 5X + 16X
  mcm_add #(.AW(FIVE_W), .BW(IN_W+4), .SW(IN_W+EXT_21)) u_add21 (
    .opA(fiveX), .opB({xIn, 4'b0000}), .sum(prod21));

  // 18X: no adder
  assign prod18 = {prod9, 1'b0};

  // R2 / R3: adjacent products differ by a pure shift of the operand
  always_comb begin
    if (!$isunknown(xIn)) begin
      p_gap13_r2: assert ((IN_W+6)'(prod13) == (IN_W+6)'(prod9) + (IN_W+6)'({xIn, 2'b00}))
        else $error("13X-9X gap wrong");
      p_gap21_r3: assert ((IN_W+6)'(prod21) == (IN_W+6)'(prod13) + (IN_W+6)'({xIn, 3'b000}))
        else $error("21X-13X gap wrong");
    end
  end
endmodule

// File: rtl/mcm_factor45.sv
// Single-constant path: 45X = 5X * 9 = 5X + (5X << 3).
module mcm_factor45
  import mcm_pkg::*;
#(
  parameter int unsigned IN_W = 8
) (
  input  logic [IN_W-1:0]        xIn,
  output logic [IN_W+EXT_45-1:0] prod45
);
  localparam int unsigned FIVE_W = IN_W + EXT_5;

  logic [FIVE_W-1:0] fiveX;

  mcm_add #(.AW(IN_W+2), .BW(IN_W), .SW(FIVE_W)) u_addA (
    .opA({xIn, 2'b00}), .opB(xIn), .sum(fiveX));

  mcm_add #(.AW(FIVE_W), .BW(FIVE_W+3), .SW(IN_W+EXT_45)) u_addB (
    .opA(fiveX), .opB({fiveX, 3'b000}), .sum(prod45));
endmodule

// File: rtl/const_mult_bank.sv
module const_mult_bank
  import mcm_pkg::*;
#(
  parameter int unsigned IN_W = 8
) (
  input  logic [IN_W-1:0]        xIn,
  output logic [IN_W+EXT_9-1:0]  prod9,
  output logic [IN_W+EXT_13-1:0] prod13,
  output logic [IN_W+EXT_18-1:0] prod18,
  output logic [IN_W+EXT_21-1:0] prod21,
  output logic [IN_W+EXT_45-1:0] prod45
);
  localparam int unsigned CHK_W = IN_W + 8;

  mcm_shared_core #(.IN_W(IN_W)) u_core (
    .xIn(xIn), .prod9(prod9), .prod13(prod13),
    .prod18(prod18), .prod21(prod21));

  mcm_factor45 #(.IN_W(IN_W)) u_f45 (
    .xIn(xIn), .prod45(prod45));

  logic [CHK_W-1:0] ext9, ext18, ext21, ext45, ext3x;
  assign ext9  = CHK_W'(prod9);
  assign ext18 = CHK_W'(prod18);
  assign ext21 = CHK_W'(prod21);
  assign ext45 = CHK_W'(prod45);
  assign ext3x = CHK_W'({xIn, 1'b0}) + CHK_W'(xIn);

  always_comb begin
    if (!$isunknown(xIn)) begin
      // R4: 18X plus 3X lands on 21X from a different adder
      p_sum18_r4: assert (ext18 + ext3x == ext21)
        else $error("18X+3X != 21X");
      // R5: the factored path agrees with 5 * (9X) from the shared graph
      p_match45_r5: assert (ext45 == (ext9 << 2) + ext9)
        else $error("45X != 5*9X");
      // R7: zero operand gives zero everywhere
      p_zero_r7: assert ((xIn != '0) || (prod9 == '0 && prod13 == '0 &&
                         prod18 == '0 && prod21 == '0 && prod45 == '0))
        else $error("nonzero output for zero operand");
    end
  end
endmodule

// File: tb/const_mult_bank_tb.sv
module const_mult_bank_tb;
  localparam int unsigned W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] xIn = '0;
  logic [W+3:0] prod9;
  logic [W+3:0] prod13;
  logic [W+4:0] prod18;
  logic [W+4:0] prod21;
  logic [W+5:0] prod45;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    longint x;
  } item_t;
  item_t expQ[$];

  always #5 clk = ~clk;

  const_mult_bank #(.IN_W(W)) u_dut (
    .xIn(xIn), .prod9(prod9), .prod13(prod13),
    .prod18(prod18), .prod21(prod21), .prod45(prod45));

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s x=%0d actual=%0d expected=%0d", req, xIn, act, exp);
    end
  endtask

  // driver: apply an operand on a rising edge and queue its expectation
  task automatic drive(input longint v);
    item_t it;
    @(posedge clk);
    xIn <= v[W-1:0];
    it.x = v;
    expQ.push_back(it);
  endtask

  // monitor: compare away from the rising edge
  always @(negedge clk) begin
    if (!rst && expQ.size() > 0) begin
      item_t it;
      it = expQ.pop_front();
      if (it.x == 0) begin
        check("R7 prod9",  longint'(prod9),  0);
        check("R7 prod45", longint'(prod45), 0);
      end
      if (it.x == (1 << W) - 1) begin
        check("R6 prod21 at max", longint'(prod21), 21 * it.x);
        check("R6 prod45 at max", longint'(prod45), 45 * it.x);
      end
      check("R1 prod9",  longint'(prod9),  9 * it.x);
      check("R2 prod13", longint'(prod13), 13 * it.x);
      check("R3 prod21", longint'(prod21), 21 * it.x);
      check("R4 prod18", longint'(prod18), 18 * it.x);
      check("R4 prod18 lsb", longint'(prod18[0]), 0);
      check("R5 prod45", longint'(prod45), 45 * it.x);
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    rst <= 1'b0;
    // R6: port widths
    check("R6 width prod9",  $bits(prod9),  W + 4);
    check("R6 width prod13", $bits(prod13), W + 4);
    check("R6 width prod18", $bits(prod18), W + 5);
    check("R6 width prod21", $bits(prod21), W + 5);
    check("R6 width prod45", $bits(prod45), W + 6);
    // zero and max first, then the full sweep
    drive(0);
    drive((1 << W) - 1);
    for (int v = 0; v < (1 << W); v++) drive(v);
    drive(0);
    wait (expQ.size() == 0);
    @(negedge clk);
    // R8: change operand between edges, no clock edge in between
    #1 xIn = 8'd37;
    #1 check("R8 prod13 no clock", longint'(prod13), 13 * 37);
    xIn = 8'd200;
    #1 check("R8 prod45 no clock", longint'(prod45), 45 * 200);
    check("R8 prod18 no clock", longint'(prod18), 18 * 200);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule